// File: doc/BRIEF.md
# Two-Way Byte Mailbox with Handshake Flags

This block passes single bytes between a host processor and an I/O controller processor that share one clock. Each direction has its own one-byte holding register. A four-bit status word tracks the handshake. One flag marks the controller-to-host byte as waiting, one marks the host-to-controller byte as waiting, and two user flags carry extra meaning between the two sides.

The host writes a byte as either data or a command. The kind is recorded in user flag F1. The host takes the controller's byte and sees the status word as stored. The controller side works with active-low data: bytes written by the controller are stored inverted, and bytes read by it come out inverted. Its view of the status is also inverted, with the unused upper bits forced high.

The controller drives the user flags through dedicated strobes. F0 is loaded from an address bit. F1 has separate set and clear strobes. Every access is a one-cycle strobe. When a set and a clear of the same flag meet in one cycle, the set takes effect.

Top module: `mbx_mailbox`

## Requirements
- R1: Synchronous active-low reset sets the status word to 4'hF, so all four flags read as 1. It also clears both holding registers: `h_rdata` reads 8'h00 and `c_rdata` reads 8'hFF.
- R2: Status bit positions: bit 0 is controller-to-host full (OBF), bit 1 is host-to-controller full (IBF), bit 2 is F0, bit 3 is F1. A host data write (`h_wr_data`) stores `h_wdata`, sets IBF and clears F1.
- R3: A host command write (`h_wr_cmd`) stores `h_wdata`, sets IBF and sets F1.
- R4: A host read strobe (`h_rd_data`) clears OBF. Outside a same-cycle set, it leaves the other flags unchanged.
- R5: `c_rdata` always shows the bitwise complement of the last host-written byte. A controller read strobe (`c_rd_data`) clears IBF.
- R6: A controller write (`c_wr_data`) makes `h_rdata` equal to the complement of `c_wdata` from the next cycle on. The same write sets OBF when `c_addr0` is 0 and clears OBF when `c_addr0` is 1.
- R7: A controller F0 write (`c_f0_wr`) loads F0 with `c_addr0`.
- R8: `c_f1_set` sets F1 and `c_f1_clr` clears F1.
- R9: `h_status` is the status word unchanged. `c_status` is {4'hF, complement of the status word}.
- R10: When a set and a clear of one flag arrive in the same cycle, the flag ends at 1.
- R11: In a cycle with no strobes, the flags and both holding registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_data | input | 1 | Host writes a data byte |
| h_wr_cmd | input | 1 | Host writes a command byte |
| h_wdata | input | 8 | Host write byte |
| h_rd_data | input | 1 | Host consumes the controller's byte |
| h_rdata | output | 8 | Controller-to-host byte as seen by the host |
| h_status | output | 4 | Status word, host view |
| c_wr_data | input | 1 | Controller writes a byte |
| c_addr0 | input | 1 | Controller address bit 0 (OBF control or F0 value) |
| c_wdata | input | 8 | Controller write byte (active-low) |
| c_rd_data | input | 1 | Controller consumes the host's byte |
| c_rdata | output | 8 | Host-to-controller byte, inverted |
| c_status | output | 8 | Status word, controller view |
| c_f0_wr | input | 1 | Controller loads F0 from `c_addr0` |
| c_f1_set | input | 1 | Controller sets F1 |
| c_f1_clr | input | 1 | Controller clears F1 |

## Verification
The assertions check the following on every cycle:
- the effect of each strobe on its flag one cycle later;
- set priority within each flag cell;
- that flags hold when their cell receives no strobe;
- that the host sees the inverted controller byte after a write.

Some behaviour only the bench scenarios can show:
- the exact status values through a handshake sequence;
- the inverted controller status view;
- collisions between host and controller strobes in one cycle;
- restart of all state by a reset in the middle of a run.

// File: rtl/mbx_pkg.sv
// Package: status bit positions and reset value shared by the mailbox.
// Assumes a four-bit status word; bit order is decoded by software on both sides.
package mbx_pkg;
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_F0  = 2;
    localparam int ST_F1  = 3;
    localparam int ST_W   = 4;
    typedef logic [ST_W-1:0] mbx_status_t;
    localparam mbx_status_t ST_RESET = 4'hF;
endpackage

// File: rtl/mbx_flag.sv
// Module: one status flag with set-over-clear priority.
// Assumes set and clr are single-cycle strobes in the clk domain.
module mbx_flag #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Update the flag: reset value, then set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/mbx_buffer.sv
// Module: one holding register; INV_IN selects storing the complement.
// Assumes load is a single-cycle strobe; contents clear to zero on reset.
module mbx_buffer #(
    parameter int W      = 8,
    parameter bit INV_IN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] din_sel;

    generate
        if (INV_IN) begin : g_inv
            // Active-low source: keep the complement.
            always_comb din_sel = ~din;
        end else begin : g_pass
            // Active-high source: keep the value as given.
            always_comb din_sel = din;
        end
    endgenerate

    // Load the register on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din_sel;
    end

    assert_buf_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/mbx_mailbox.sv
// Module: two-way byte mailbox between a host and an I/O controller.
// Assumes one clock domain and single-cycle strobes; set beats clear per flag.
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr_data,
    input  logic          h_wr_cmd,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_rd_data,
    output logic [DW-1:0] h_rdata,
    output logic [ST_W-1:0] h_status,
    input  logic          c_wr_data,
    input  logic          c_addr0,
    input  logic [DW-1:0] c_wdata,
    input  logic          c_rd_data,
    output logic [DW-1:0] c_rdata,
    output logic [DW-1:0] c_status,
    input  logic          c_f0_wr,
    input  logic          c_f1_set,
    input  logic          c_f1_clr
);
    localparam int PAD_W = DW - ST_W;

    mbx_status_t set_v, clr_v, stat_q;
    logic [DW-1:0] ibuf_q, obuf_q;
    logic host_wr;

    // Decode every strobe into per-flag set and clear requests.
    always_comb begin
        host_wr       = h_wr_data | h_wr_cmd;
        set_v         = '0;
        clr_v         = '0;
        set_v[ST_OBF] = c_wr_data & ~c_addr0;
        clr_v[ST_OBF] = h_rd_data | (c_wr_data & c_addr0);
        set_v[ST_IBF] = host_wr;
        clr_v[ST_IBF] = c_rd_data;
        set_v[ST_F0]  = c_f0_wr & c_addr0;
        clr_v[ST_F0]  = c_f0_wr & ~c_addr0;
        set_v[ST_F1]  = h_wr_cmd | c_f1_set;
        clr_v[ST_F1]  = h_wr_data | c_f1_clr;
    end

    genvar gi;
    generate
        for (gi = 0; gi < ST_W; gi++) begin : g_flag
            mbx_flag #(.RST_VAL(ST_RESET[gi])) u_flag (
                .clk(clk), .rst_n(rst_n),
                .set(set_v[gi]), .clr(clr_v[gi]), .q(stat_q[gi])
            );
        end
    endgenerate

    mbx_buffer #(.W(DW), .INV_IN(1'b0)) u_ibuf (
        .clk(clk), .rst_n(rst_n), .load(host_wr), .din(h_wdata), .q(ibuf_q)
    );
    mbx_buffer #(.W(DW), .INV_IN(1'b1)) u_obuf (
        .clk(clk), .rst_n(rst_n), .load(c_wr_data), .din(c_wdata), .q(obuf_q)
    );

    // Present each side's view of buffers and status.
    always_comb begin
        h_rdata  = obuf_q;
        c_rdata  = ~ibuf_q;
        h_status = stat_q;
        c_status = {{PAD_W{1'b1}}, ~stat_q};
    end

    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_data || h_wr_cmd) |=> h_status[ST_IBF]);
    assert_f1_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_data && !h_wr_cmd && !c_f1_set) |=> !h_status[ST_F1]);
    assert_f1_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr_cmd |=> h_status[ST_F1]);
    assert_obf_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_data && !(c_wr_data && !c_addr0)) |=> !h_status[ST_OBF]);
    assert_ibf_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_data && !h_wr_data && !h_wr_cmd) |=> !h_status[ST_IBF]);
    assert_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_data || h_wr_cmd) |=> (c_rdata == ~$past(h_wdata)));
    assert_obuf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_data |=> (h_rdata == ~$past(c_wdata)));
    assert_obf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_data && !c_addr0) |=> h_status[ST_OBF]);
    assert_f0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_f0_wr |=> (h_status[ST_F0] == $past(c_addr0)));
    assert_f1_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_f1_clr && !c_f1_set && !h_wr_cmd) |=> !h_status[ST_F1]);
endmodule

// File: tb/sim_mbx_mailbox.sv
// Bench: walks a vector table through the mailbox, then runs directed reset checks.
module sim_mbx_mailbox;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_wr_data = 0, h_wr_cmd = 0, h_rd_data = 0;
    logic c_wr_data = 0, c_addr0 = 0, c_rd_data = 0;
    logic c_f0_wr = 0, c_f1_set = 0, c_f1_clr = 0;
    logic [7:0] h_wdata = 0, c_wdata = 0;
    logic [7:0] h_rdata, c_rdata, c_status;
    logic [3:0] h_status;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mbx_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .h_wr_data(h_wr_data), .h_wr_cmd(h_wr_cmd), .h_wdata(h_wdata),
        .h_rd_data(h_rd_data), .h_rdata(h_rdata), .h_status(h_status),
        .c_wr_data(c_wr_data), .c_addr0(c_addr0), .c_wdata(c_wdata),
        .c_rd_data(c_rd_data), .c_rdata(c_rdata), .c_status(c_status),
        .c_f0_wr(c_f0_wr), .c_f1_set(c_f1_set), .c_f1_clr(c_f1_clr)
    );

    // Row: {strobes hwd,hwc,hrd,cwd,crd,cf0,f1s,f1c ; a0 ; h_wdata ; c_wdata ; status ; h_rdata ; c_rdata}
    localparam int NV = 17;
    localparam logic [44:0] VEC [NV] = '{
        {8'b0010_0000, 1'b0, 8'h00, 8'h00, 4'hE, 8'h00, 8'hFF}, // R4 host read clears OBF
        {8'b0000_1000, 1'b0, 8'h00, 8'h00, 4'hC, 8'h00, 8'hFF}, // R5 ctrl read clears IBF
        {8'b0000_0001, 1'b0, 8'h00, 8'h00, 4'h4, 8'h00, 8'hFF}, // R8 clear F1
        {8'b0000_0100, 1'b0, 8'h00, 8'h00, 4'h0, 8'h00, 8'hFF}, // R7 F0 <- 0
        {8'b1000_0000, 1'b0, 8'hA5, 8'h00, 4'h2, 8'h00, 8'h5A}, // R2 data write
        {8'b0000_1000, 1'b0, 8'h00, 8'h00, 4'h0, 8'h00, 8'h5A}, // R5 read
        {8'b0100_0000, 1'b0, 8'h3C, 8'h00, 4'hA, 8'h00, 8'hC3}, // R3 command write
        {8'b0001_0000, 1'b0, 8'h00, 8'h96, 4'hB, 8'h69, 8'hC3}, // R6 write, a0=0 sets OBF
        {8'b0001_0000, 1'b1, 8'h00, 8'h11, 4'hA, 8'hEE, 8'hC3}, // R6 write, a0=1 clears OBF
        {8'b0000_0100, 1'b1, 8'h00, 8'h00, 4'hE, 8'hEE, 8'hC3}, // R7 F0 <- 1
        {8'b0011_0000, 1'b0, 8'h00, 8'h7E, 4'hF, 8'h81, 8'hC3}, // R10 OBF set beats host read
        {8'b0000_0001, 1'b0, 8'h00, 8'h00, 4'h7, 8'h81, 8'hC3}, // R8 clear F1
        {8'b1000_0010, 1'b0, 8'h81, 8'h00, 4'hF, 8'h81, 8'h7E}, // R10 F1 set beats data write
        {8'b1000_1000, 1'b0, 8'h42, 8'h00, 4'h7, 8'h81, 8'hBD}, // R10 IBF set beats ctrl read, R2
        {8'b0000_0011, 1'b0, 8'h00, 8'h00, 4'hF, 8'h81, 8'hBD}, // R10 F1 set+clear
        {8'b0000_0000, 1'b0, 8'hFF, 8'hFF, 4'hF, 8'h81, 8'hBD}, // R11 idle leaves state
        {8'b0010_1000, 1'b0, 8'h00, 8'h00, 4'hC, 8'h81, 8'hBD}  // R4 R5 both reads
    };
    localparam int TAG [NV] = '{4, 5, 8, 7, 2, 5, 3, 6, 6, 7, 10, 8, 10, 10, 10, 11, 4};

    // Compare one value and report a failure line on mismatch.
    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Check every output against the expected state (R9 views included).
    task automatic chk_all(input int req, input logic [3:0] st, input logic [7:0] hr, input logic [7:0] cr);
        chk(req, "h_status", {4'h0, h_status}, {4'h0, st});
        chk(9, "c_status", c_status, {4'hF, ~st});
        chk(req, "h_rdata", h_rdata, hr);
        chk(req, "c_rdata", c_rdata, cr);
    endtask

    task automatic set_strobes(input logic [7:0] s);
        {h_wr_data, h_wr_cmd, h_rd_data, c_wr_data, c_rd_data, c_f0_wr, c_f1_set, c_f1_clr} = s;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 4'hF, 8'h00, 8'hFF);  // R1 reset state
        for (int i = 0; i < NV; i++) begin
            set_strobes(VEC[i][44:37]);
            c_addr0 = VEC[i][36];
            h_wdata = VEC[i][35:28];
            c_wdata = VEC[i][27:20];
            @(negedge clk);
            set_strobes(8'h00);
            chk_all(TAG[i], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0]);
        end
        // R1 reset in mid-run restores every output.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 4'hF, 8'h00, 8'hFF);
        // R1 reset beats a strobe in the same cycle.
        rst_n = 1'b0;
        set_strobes(8'b0101_0000);
        h_wdata = 8'h12;
        c_wdata = 8'h34;
        @(negedge clk);
        set_strobes(8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 4'hF, 8'h00, 8'hFF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule